// File: doc/BRIEF.md
# Serial Shift Transfer Wait Controller

This block moves one byte at a time over a three-wire synchronous serial link: shift clock, serial data out and serial data in. A single run flag decides whether it is paused or moving data. While paused, the shift clock generator and the shift register are frozen and the link is quiet. Software loads the outgoing byte, writes 1 to the run flag and polls the flag. When the flag reads 0 again, the exchange is over and the received byte can be read.

Writing 0 to the flag during an exchange aborts it at once and clears the edge counter, so the next start always performs a full eight-bit exchange. In master mode the block makes its own shift clock from the system clock, with a parameterised half period. In slave mode it follows an external shift clock, which is first brought into the system clock domain through a synchronizer.

The control is a three-state machine:
- `ST_WAIT` is the paused state, with the clock idle high.
- `ST_HIGH` is the high clock phase.
- `ST_LOW` is the low clock phase.

It has these transitions:
- `ST_WAIT -> ST_HIGH` on a start write.
- `ST_HIGH -> ST_LOW` on a falling shift edge.
- `ST_LOW -> ST_HIGH` on a rising shift edge while fewer than eight falling edges have been counted.
- `ST_LOW -> ST_WAIT` on a rising shift edge once the counter holds eight (completion).
- `ST_HIGH/ST_LOW -> ST_WAIT` on a stop write (forced wait).

Top module: `sio_wait_ctrl`

## Requirements
- R1: After reset the run flag reads 0, `sck_o` is 1, `sdo` is 1 and the shift register reads 0x00.
- R2: A register write with `wr_addr`=0 and `wr_data[0]`=1 while paused sets the run flag. The flag is visible on `rd_data[0]` (with `rd_addr`=0) from the next cycle.
- R3: In master mode the shift clock is low for `HALF_PERIOD` cycles and high for `HALF_PERIOD` cycles, and it makes exactly eight low pulses per exchange. The first falling edge comes `HALF_PERIOD` cycles after the start write is taken. `sck_o` stays 1 whenever the flag is 0, and always in slave mode.
- R4: On each falling shift edge, `sdo` takes the current most significant bit of the shift register, so the byte leaves MSB first.
- R5: On each rising shift edge, `sdi` is shifted into the least significant bit. After completion, a read with `rd_addr`=1 returns the eight received bits, the first received bit in the MSB.
- R6: The exchange ends on the rising shift edge seen while the falling-edge counter holds 8. The flag then clears by itself, 16×`HALF_PERIOD` cycles after the start write in master mode.
- R7: A write with `wr_addr`=0 and `wr_data[0]`=0 during an exchange forces the paused state on the next cycle: the flag reads 0 and `sck_o` is 1. The next start runs a full eight-edge exchange.
- R8: A write of 1 to the flag during an exchange is ignored: the exchange length is unchanged.
- R9: A write with `wr_addr`=1 loads the shift register only while paused and is ignored during an exchange. A read with `rd_addr`=1 returns the current register contents at any time and does not disturb the exchange.
- R10: In slave mode, shift edges come from `sck_i` after a `SYNC_STAGES`-flop synchronizer and one more flop for edge detection.
- R11: While paused, activity on `sdi` and `sck_i` changes neither the shift register nor `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1: follow `sck_i`; 0: generate the shift clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: run flag (bit 0), 1: shift data |
| wr_data | input | DATA_BITS | Write data |
| rd_addr | input | 1 | 0: run flag in bit 0, 1: shift data |
| rd_data | output | DATA_BITS | Read data |
| sck_o | output | 1 | Master shift clock, idle high |
| sck_i | input | 1 | External shift clock for slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A wrong state or counter value in this block shows up as an early or late `sck_o` edge within one half period, or as a run flag that clears at the wrong cycle. A shift-register fault appears on `sdo` at the next falling edge and in the received byte at completion. A behavioural model in the bench predicts `sck_o`, `sdo` and `rd_data` for every cycle, so any such deviation is flagged in the cycle it first reaches a port. Directed checks add the exchange length, the bit order, abort, ignored writes and slave timing.

// File: rtl/sio_wait_pkg.sv
package sio_wait_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/sio_sck_events.sv
module sio_sck_events
    import sio_wait_pkg::*;
#(
    parameter int HALF_PERIOD = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slave_mode,
    input  xfer_state_e state,
    input  logic        sck_in,
    output logic        fall_ev,
    output logic        rise_ev
);
    localparam int DIV_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_PERIOD - 1);

    logic [DIV_W-1:0]       div_q;
    logic                   tick;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   sck_s;
    logic                   ext_fall;
    logic                   ext_rise;

    // Half-period divider, held at zero while paused
    assign tick = (state != ST_WAIT) && (div_q == DIV_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (state == ST_WAIT || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // Synchronizer for the external shift clock
    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= sck_in;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], sck_in};
            end
        end
    endgenerate

    assign sck_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sck_s;
    end

    assign ext_fall = prev_q & ~sck_s;
    assign ext_rise = ~prev_q & sck_s;

    // Edge events, qualified by the phase the state machine is in
    always_comb begin
        fall_ev = 1'b0;
        rise_ev = 1'b0;
        unique case (state)
            ST_HIGH: fall_ev = slave_mode ? ext_fall : tick;
            ST_LOW:  rise_ev = slave_mode ? ext_rise : tick;
            default: begin
                fall_ev = 1'b0;
                rise_ev = 1'b0;
            end
        endcase
    end

    assert_wait_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (!fall_ev && !rise_ev))
        else $error("shift edge reported while paused");

endmodule

// File: rtl/sio_wait_fsm.sv
module sio_wait_fsm
    import sio_wait_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req,
    input  logic        stop_req,
    input  logic        fall_ev,
    input  logic        rise_ev,
    output xfer_state_e state,
    output logic        busy,
    output logic        out_en,
    output logic        in_en
);
    localparam int CNT_W = $clog2(DATA_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_BITS);

    xfer_state_e      state_q;
    xfer_state_e      state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             last_edge;

    assign last_edge = rise_ev && (cnt_q == CNT_FULL);

    // State and counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_WAIT: begin
                cnt_d = '0;
                if (start_req) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (stop_req) begin
                    state_d = ST_WAIT;
                    cnt_d   = '0;
                end else if (fall_ev) begin
                    state_d = ST_LOW;
                    cnt_d   = cnt_q + CNT_W'(1);
                end
            end
            ST_LOW: begin
                if (stop_req) begin
                    state_d = ST_WAIT;
                    cnt_d   = '0;
                end else if (last_edge) begin
                    state_d = ST_WAIT;
                    cnt_d   = '0;
                end else if (rise_ev) begin
                    state_d = ST_HIGH;
                end
            end
            default: begin
                state_d = ST_WAIT;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        state  = state_q;
        busy   = 1'b0;
        out_en = 1'b0;
        in_en  = 1'b0;
        unique case (state_q)
            ST_WAIT: busy = 1'b0;
            ST_HIGH: begin
                busy   = 1'b1;
                out_en = fall_ev && !stop_req;
            end
            ST_LOW: begin
                busy  = 1'b1;
                in_en = rise_ev && !stop_req;
            end
            default: busy = 1'b0;
        endcase
    end

    assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && rise_ev && !stop_req && cnt_q == CNT_FULL)
        |=> (state_q == ST_WAIT && cnt_q == '0))
        else $error("completion edge did not return to wait");

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL)
        else $error("edge counter beyond data width");

    assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WAIT && stop_req) |=> (state_q == ST_WAIT && cnt_q == '0))
        else $error("forced wait not taken");

    assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && start_req && !stop_req) |=> (state_q != ST_WAIT))
        else $error("start write disturbed a running exchange");

endmodule

// File: rtl/sio_shift_reg.sv
module sio_shift_reg #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [DATA_BITS-1:0] load_data,
    input  logic                 out_en,
    input  logic                 in_en,
    input  logic                 sdi,
    output logic [DATA_BITS-1:0] data,
    output logic                 sdo
);
    logic [DATA_BITS-1:0] data_q;
    logic                 sdo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_en) begin
            data_q <= load_data;
        end else if (in_en) begin
            data_q <= {data_q[DATA_BITS-2:0], sdi};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      sdo_q <= 1'b1;
        else if (out_en) sdo_q <= data_q[DATA_BITS-1];
    end

    assign data = data_q;
    assign sdo  = sdo_q;

    assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !in_en) |=> $stable(data_q))
        else $error("shift register moved without an enable");

    assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> $stable(sdo_q))
        else $error("serial output moved without a falling edge");

endmodule

// File: rtl/sio_wait_ctrl.sv
module sio_wait_ctrl
    import sio_wait_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int HALF_PERIOD = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slave_mode,
    input  logic                 wr_en,
    input  logic                 wr_addr,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 rd_addr,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 sck_o,
    input  logic                 sck_i,
    output logic                 sdo,
    input  logic                 sdi
);
    xfer_state_e          state;
    logic                 busy;
    logic                 fall_ev;
    logic                 rise_ev;
    logic                 out_en;
    logic                 in_en;
    logic                 flag_wr;
    logic                 start_req;
    logic                 stop_req;
    logic                 data_wr;
    logic [DATA_BITS-1:0] shreg;

    // Register port decode
    assign flag_wr   = wr_en && !wr_addr;
    assign start_req = flag_wr && wr_data[0];
    assign stop_req  = flag_wr && !wr_data[0];
    assign data_wr   = wr_en && wr_addr && !busy;

    sio_sck_events #(
        .HALF_PERIOD (HALF_PERIOD),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (slave_mode),
        .state      (state),
        .sck_in     (sck_i),
        .fall_ev    (fall_ev),
        .rise_ev    (rise_ev)
    );

    sio_wait_fsm #(
        .DATA_BITS (DATA_BITS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .fall_ev   (fall_ev),
        .rise_ev   (rise_ev),
        .state     (state),
        .busy      (busy),
        .out_en    (out_en),
        .in_en     (in_en)
    );

    sio_shift_reg #(
        .DATA_BITS (DATA_BITS)
    ) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (data_wr),
        .load_data (wr_data),
        .out_en    (out_en),
        .in_en     (in_en),
        .sdi       (sdi),
        .data      (shreg),
        .sdo       (sdo)
    );

    assign sck_o   = slave_mode || (state != ST_LOW);
    assign rd_data = rd_addr ? shreg : {{(DATA_BITS-1){1'b0}}, busy};

    assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_o)
        else $error("shift clock low while paused");

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req) |=> busy)
        else $error("start write did not raise the run flag");

endmodule

// File: tb/sio_wait_ctrl_test.sv
`timescale 1ns/100ps
module sio_wait_ctrl_test;
    localparam int HALF = 2;
    localparam int NB   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [NB-1:0] wr_data = '0;
    logic          rd_addr = 1'b0;
    logic [NB-1:0] rd_data;
    logic          sck_o;
    logic          sck_i = 1'b1;
    logic          sdo;
    logic          sdi;
    logic          sdi_drv = 1'b0;
    logic          loop_en = 1'b0;

    assign sdi = loop_en ? sdo : sdi_drv;

    always #2 clk = ~clk;

    sio_wait_ctrl #(.DATA_BITS(NB), .HALF_PERIOD(HALF), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sck_o(sck_o), .sck_i(sck_i), .sdo(sdo), .sdi(sdi)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    bit       m_run = 0, m_hi = 1;
    int       m_div = 0, m_cnt = 0;
    bit [7:0] m_sr = 0;
    bit       m_sdo = 1;
    bit       h1 = 1, h2 = 1, h3 = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_hi = 1; m_div = 0; m_cnt = 0; m_sr = 0; m_sdo = 1;
            h1 = 1; h2 = 1; h3 = 1;
        end else begin
            bit fall, rise, stop, start, load, fin;
            fall = 0; rise = 0;
            if (slave_mode) begin
                fall = m_run && m_hi && h3 && !h2;
                rise = m_run && !m_hi && !h3 && h2;
            end else if (m_run && m_div == HALF - 1) begin
                if (m_hi) fall = 1; else rise = 1;
            end
            stop  = wr_en && !wr_addr && !wr_data[0] && m_run;
            start = wr_en && !wr_addr && wr_data[0] && !m_run;
            load  = wr_en && wr_addr && !m_run;
            fin   = rise && !stop && m_cnt == NB;
            if (fall && !stop) m_sdo = m_sr[7];
            if (load) m_sr = wr_data;
            else if (rise && !stop) m_sr = {m_sr[6:0], sdi};
            if (!m_run || (m_div == HALF - 1)) m_div = 0; else m_div++;
            if (start || stop || fin) m_cnt = 0;
            else if (fall) m_cnt++;
            if (stop || fin) begin m_run = 0; m_hi = 1; end
            else if (start) begin m_run = 1; m_hi = 1; end
            else if (fall) m_hi = 0;
            else if (rise) m_hi = 1;
            h3 = h2; h2 = h1; h1 = sck_i;
        end
    end

    // Per-cycle comparison and edge monitor
    bit       prev_sck = 1;
    int       falls = 0;
    bit [7:0] bits = 0;

    always @(posedge clk) begin
        #1;
        chk(sck_o === (slave_mode || !m_run || m_hi), "R3", "model sck_o", sck_o,
            slave_mode || !m_run || m_hi);
        chk(sdo === m_sdo, "R4", "model sdo", sdo, m_sdo);
        if (rd_addr)
            chk(rd_data === m_sr, "R5", "model shift data", rd_data, m_sr);
        else
            chk(rd_data === {7'b0, m_run}, "R2", "model run flag", rd_data, m_run);
        if (rst_n) begin
            if (!sck_o && prev_sck) falls++;
            if (sck_o && !prev_sck) bits = {bits[6:0], sdo};
        end
        prev_sck = sck_o;
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic write_reg(input bit a, input bit [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0; wr_data = 0;
    endtask

    task automatic read_data(output bit [7:0] d);
        rd_addr = 1;
        #0.5;
        d = rd_data;
        rd_addr = 0;
    endtask

    // Starts an exchange and counts cycles until the flag reads 0.
    // inject: 0 none, 1 rewrite flag to 1, 2 data write, 3 abort (cycle 10)
    task automatic run_xfer(input int inject, output int cycles);
        falls = 0;
        write_reg(0, 8'h01);
        cycles = 0;
        while (rd_data[0] && cycles < 2000) begin
            step();
            cycles++;
            wr_en = 0;
            if (cycles == 5 && inject == 1) begin wr_en = 1; wr_addr = 0; wr_data = 8'h01; end
            if (cycles == 5 && inject == 2) begin wr_en = 1; wr_addr = 1; wr_data = 8'h00; end
            if (cycles == 10 && inject == 3) begin wr_en = 1; wr_addr = 0; wr_data = 8'h00; end
        end
        wr_en = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit [7:0] d;
        int cyc;
        repeat (3) step();
        chk(rd_data[0] === 1'b0, "R1", "flag after reset", rd_data[0], 0);
        chk(sck_o === 1'b1, "R1", "sck_o after reset", sck_o, 1);
        chk(sdo === 1'b1, "R1", "sdo after reset", sdo, 1);
        read_data(d);
        chk(d == 8'h00, "R1", "data after reset", d, 0);
        rst_n = 1;
        step();

        // load and read back while paused
        write_reg(1, 8'hA5);
        read_data(d);
        chk(d == 8'hA5, "R9", "load while paused", d, 8'hA5);

        // master exchange with loopback
        loop_en = 1;
        wr_en = 1; wr_addr = 0; wr_data = 8'h01;
        step();
        wr_en = 0;
        chk(rd_data[0] === 1'b1, "R2", "flag one cycle after start", rd_data[0], 1);
        falls = 0;
        cyc = 0;
        while (rd_data[0] && cyc < 2000) begin step(); cyc++; end
        chk(cyc == 16 * HALF, "R6", "master exchange length", cyc, 16 * HALF);
        chk(falls == 8, "R3", "low pulses per exchange", falls, 8);
        chk(bits == 8'hA5, "R4", "MSB-first bit order on sdo", bits, 8'hA5);
        read_data(d);
        chk(d == 8'hA5, "R5", "loopback received byte", d, 8'hA5);

        // fixed sdi pattern
        loop_en = 0; sdi_drv = 1;
        write_reg(1, 8'h3C);
        run_xfer(0, cyc);
        read_data(d);
        chk(d == 8'hFF, "R5", "received all-ones", d, 8'hFF);
        chk(bits == 8'h3C, "R4", "sdo bits of 0x3C", bits, 8'h3C);

        // start write during exchange ignored
        write_reg(1, 8'h0F);
        run_xfer(1, cyc);
        chk(cyc == 16 * HALF, "R8", "length with repeated start", cyc, 16 * HALF);

        // data write during exchange ignored
        sdi_drv = 0;
        write_reg(1, 8'hC3);
        run_xfer(2, cyc);
        read_data(d);
        chk(d == 8'h00, "R9", "data write while busy ignored", d, 8'h00);

        // forced wait
        write_reg(1, 8'h5A);
        run_xfer(3, cyc);
        chk(cyc == 11, "R7", "abort takes effect next cycle", cyc, 11);
        chk(sck_o === 1'b1, "R7", "sck_o high after abort", sck_o, 1);
        run_xfer(0, cyc);
        chk(cyc == 16 * HALF, "R7", "full length after abort", cyc, 16 * HALF);
        chk(falls == 8, "R7", "eight edges after abort", falls, 8);

        // paused state frozen
        slave_mode = 1;
        write_reg(1, 8'h96);
        for (int i = 0; i < 20; i++) begin
            sdi_drv = i[0]; sck_i = i[1];
            step();
        end
        sck_i = 1;
        repeat (4) step();
        read_data(d);
        chk(d == 8'h96, "R11", "data frozen while paused", d, 8'h96);
        chk(sdo === 1'b0, "R11", "sdo frozen while paused", sdo, 0);
        chk(rd_data[0] === 1'b0, "R11", "flag stays clear", rd_data[0], 0);

        // slave exchange
        falls = 0;
        write_reg(0, 8'h01);
        for (int i = 7; i >= 0; i--) begin
            sck_i = 0; sdi_drv = 8'h6B >> i;
            repeat (4) step();
            sck_i = 1;
            if (i == 0) begin
                step(); step();
                chk(rd_data[0] === 1'b1, "R10", "flag before synchronized last edge",
                    rd_data[0], 1);
                step();
                chk(rd_data[0] === 1'b0, "R10", "flag after synchronized last edge",
                    rd_data[0], 0);
                step();
            end else begin
                repeat (4) step();
            end
        end
        read_data(d);
        chk(d == 8'h6B, "R10", "slave received byte", d, 8'h6B);
        chk(falls == 0, "R3", "sck_o idle in slave mode", falls, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule